// File: doc/BRIEF.md
# Six-Source Interrupt Enable Controller

This block sits between six interrupt-flag holders and a CPU sequencer. Software writes an 8-bit enable register that holds a global enable and one enable bit per source. The sources are two external requests, three timer overflows and a serial port. The serial request is the OR of its receive and transmit flags. The third timer's request is the OR of its overflow flag and its external-event flag.

Raw flags are sampled into a pending vector on a machine-cycle phase strobe. Timers 0 and 1 pass through one extra sampling stage, so they reach the pending vector one machine cycle after the other sources. The third timer is not delayed.

Of the pending, enabled sources, the controller presents one to the CPU, chosen by a fixed polling order. It outputs a request line and a 3-bit vector index. When the CPU acknowledges, the controller pulses a hardware clear for the selected source, but only if that source is an external request or timer 0 or timer 1. The serial flags and the third timer's flags are left for software to clear.

Top module: `irqEnableCtl`

## Requirements
- R1: The enable register is written with `enWrData` while `enWrEn` is 1 and reads back on `enRdData` the next cycle. Bit 6 is unimplemented: it always reads 0 and ignores writes. After reset the register reads 0x00.
- R2: The enable register's bit 7 is the global enable. While it is 0, `intReq` is 0 whatever the other enable bits and the pending flags are.
- R3: Each enable bit gates one source. The bit numbers are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2. A pending source whose bit is 0 raises no request. It stays pending and requests once its bit is set.
- R4: When several enabled sources are pending, the one presented is chosen in this fixed order, and `intVec` carries its index: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, timer 2 = 5.
- R5: The serial request is `serRx` OR `serTx`.
- R6: The timer-2 request is `tmr2Ovf` OR `tmr2Ext`.
- R7: External, serial and timer-2 flags become pending at the first `phaseStb` clock edge that sees them. Timer-0 and timer-1 flags need two strobe edges, one machine cycle later.
- R8: `intAck` asserted while `intReq` is 1 pulses `hwClr[vec]` in the same cycle for vectors 0 to 3. The pending bit of that source is removed at the next clock edge. `hwClr` is otherwise 0 and never has more than one bit set.
- R9: An acknowledge of vector 4 or 5 produces no `hwClr` pulse (`hwClr[5:4]` is always 0), and that request stays pending.
- R10: After reset `intReq` is 0 and `hwClr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enWrEn | input | 1 | Enable register write strobe |
| enWrData | input | 8 | Enable register write data |
| enRdData | output | 8 | Enable register contents |
| ext0Req | input | 1 | External request 0 flag |
| tmr0Ovf | input | 1 | Timer 0 overflow flag |
| ext1Req | input | 1 | External request 1 flag |
| tmr1Ovf | input | 1 | Timer 1 overflow flag |
| serRx | input | 1 | Serial receive flag |
| serTx | input | 1 | Serial transmit flag |
| tmr2Ovf | input | 1 | Timer 2 overflow flag |
| tmr2Ext | input | 1 | Timer 2 external-event flag |
| phaseStb | input | 1 | Machine-cycle sampling strobe |
| intAck | input | 1 | CPU acknowledge of the presented request |
| intReq | output | 1 | Interrupt request to the CPU |
| intVec | output | 3 | Index of the presented source |
| hwClr | output | 6 | Hardware-clear pulses, one bit per vector index |

## Verification
A wrong pending bit shows on `intReq` and `intVec` in the same cycle, since the request is formed combinationally from the pending vector. A lost or extra sampling stage shows up as a request one strobe early or late on a timer source. A bad clear mask shows as a `hwClr` pulse in the cycle of the acknowledge: either on a serial or timer-2 vector, or on a bit other than the presented one. At the next edge it also shows as a request that either persists or disappears when it should not. The tests set several flags at once so that a wrong polling order changes `intVec` straight away.

// File: rtl/icPkg.sv
package icPkg;
  localparam int NUM_SRC = 6;
  localparam int VEC_W = $clog2(NUM_SRC);
  localparam int EN_W = 8;
  localparam int GLOBAL_BIT = 7;
  localparam int RSVD_BIT = 6;
  // sources cleared by hardware on acknowledge (externals, timer 0/1)
  localparam logic [NUM_SRC-1:0] HW_CLR_MASK = 6'b001111;
  // sources given an extra sampling stage (timer 0/1)
  localparam logic [NUM_SRC-1:0] LATE_MASK = 6'b001010;

  typedef struct packed {
    logic sample;
    logic take;
    logic [NUM_SRC-1:0] clrMask;
  } ctlStb_t;
endpackage

// File: rtl/icEnDatapath.sv
module icEnDatapath
  import icPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enWrEn,
  input  logic [EN_W-1:0]    enWrData,
  input  logic [NUM_SRC-1:0] rawReq,
  input  ctlStb_t            stb,
  output logic [EN_W-1:0]    enReg,
  output logic [NUM_SRC-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rstN) enReg <= '0;
    else if (enWrEn) begin
      enReg <= enWrData;
      enReg[RSVD_BIT] <= 1'b0;
    end
  end

  logic [NUM_SRC-1:0] dly;

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    if (LATE_MASK[i]) begin : gLate
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dly[i]  <= 1'b0;
          pend[i] <= 1'b0;
        end else if (stb.sample) begin
          dly[i]  <= rawReq[i] & ~stb.clrMask[i];
          pend[i] <= dly[i] & ~stb.clrMask[i];
        end else begin
          dly[i]  <= dly[i] & ~stb.clrMask[i];
          pend[i] <= pend[i] & ~stb.clrMask[i];
        end
      end
    end else begin : gEarly
      assign dly[i] = 1'b0;
      always_ff @(posedge clk) begin
        if (!rstN) pend[i] <= 1'b0;
        else if (stb.sample) pend[i] <= rawReq[i] & ~stb.clrMask[i];
        else pend[i] <= pend[i] & ~stb.clrMask[i];
      end
    end
  end

  // R1: reserved bit never holds a one
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    enReg[RSVD_BIT] == 1'b0);

  // R7: a timer 0 request only appears after passing the extra stage
  p_t0_late_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pend[1]) |-> $past(dly[1]));

  // R9: an acknowledge without a strobe leaves serial/timer-2 pending
  p_keep_soft_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.take && !stb.sample) |=> pend[5:4] == $past(pend[5:4]));
endmodule

// File: rtl/icPollCtl.sv
module icPollCtl
  import icPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               phaseStb,
  input  logic               intAck,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [EN_W-1:0]    enReg,
  output ctlStb_t            stb,
  output logic               intReq,
  output logic [VEC_W-1:0]   intVec,
  output logic [NUM_SRC-1:0] hwClr
);
  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] selOh;

  assign active = enReg[GLOBAL_BIT] ? (pend & enReg[NUM_SRC-1:0]) : '0;
  assign intReq = |active;

  always_comb begin
    intVec = '0;
    selOh  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        intVec = VEC_W'(i);
        selOh  = NUM_SRC'(1) << i;
      end
    end
  end

  assign stb.sample  = phaseStb;
  assign stb.take    = intAck & intReq;
  assign stb.clrMask = stb.take ? (selOh & HW_CLR_MASK) : '0;
  assign hwClr       = stb.clrMask;

  // R4: vector index stays within the source count
  p_vec_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> intVec < VEC_W'(NUM_SRC));

  // R8: a clear only happens under an acknowledge
  p_clr_needs_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|hwClr) |-> (intAck && intReq));
endmodule

// File: rtl/irqEnableCtl.sv
module irqEnableCtl
  import icPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enWrEn,
  input  logic [7:0] enWrData,
  output logic [7:0] enRdData,
  input  logic       ext0Req,
  input  logic       tmr0Ovf,
  input  logic       ext1Req,
  input  logic       tmr1Ovf,
  input  logic       serRx,
  input  logic       serTx,
  input  logic       tmr2Ovf,
  input  logic       tmr2Ext,
  input  logic       phaseStb,
  input  logic       intAck,
  output logic       intReq,
  output logic [2:0] intVec,
  output logic [5:0] hwClr
);
  logic [NUM_SRC-1:0] rawReq;
  logic [NUM_SRC-1:0] pend;
  logic [EN_W-1:0]    enReg;
  ctlStb_t            stb;

  assign rawReq = {tmr2Ovf | tmr2Ext, serRx | serTx, tmr1Ovf, ext1Req, tmr0Ovf, ext0Req};
  assign enRdData = enReg;

  icEnDatapath uDp (
    .clk(clk), .rstN(rstN), .enWrEn(enWrEn), .enWrData(enWrData),
    .rawReq(rawReq), .stb(stb), .enReg(enReg), .pend(pend)
  );

  icPollCtl uCtl (
    .clk(clk), .rstN(rstN), .phaseStb(phaseStb), .intAck(intAck),
    .pend(pend), .enReg(enReg), .stb(stb), .intReq(intReq),
    .intVec(intVec), .hwClr(hwClr)
  );

  // R2: global enable low blocks every request
  p_global_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enRdData[7] |-> !intReq);

  // R8: at most one clear pulse
  p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hwClr));

  // R9: serial and timer-2 flags never cleared by hardware
  p_no_soft_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    hwClr[5:4] == 2'b00);
endmodule

// File: tb/tb_irqEnableCtl.sv
`timescale 1ns/1ps
module tb_irqEnableCtl;
  logic clk = 0;
  logic rstN = 0;
  logic enWrEn = 0;
  logic [7:0] enWrData = 0;
  logic [7:0] enRdData;
  logic ext0Req = 0, tmr0Ovf = 0, ext1Req = 0, tmr1Ovf = 0;
  logic serRx = 0, serTx = 0, tmr2Ovf = 0, tmr2Ext = 0;
  logic phaseStb = 0, intAck = 0;
  logic intReq;
  logic [2:0] intVec;
  logic [5:0] hwClr;
  int nChk = 0, nErr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irqEnableCtl dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrEn(logic [7:0] v);
    @(negedge clk); enWrEn = 1; enWrData = v;
    @(negedge clk); enWrEn = 0;
  endtask

  task automatic strobe();
    @(negedge clk); phaseStb = 1;
    @(negedge clk); phaseStb = 0;
  endtask

  // acknowledge: check clear pulse in the ack cycle
  task automatic ackChk(string req, logic [5:0] expClr);
    @(negedge clk); intAck = 1;
    #1 check(req, hwClr, expClr);
    @(negedge clk); intAck = 0;
  endtask

  task automatic tReset();
    check("R10 intReq", intReq, 0);
    check("R10 hwClr", hwClr, 0);
    check("R1 reset enRd", enRdData, 8'h00);
  endtask

  task automatic tEnReg();
    wrEn(8'hFF);
    check("R1 bit6 reads 0", enRdData, 8'hBF);
    wrEn(8'h41);
    check("R1 write 41", enRdData, 8'h01);
  endtask

  task automatic tGlobal();
    wrEn(8'h3F);
    ext0Req = 1; tmr2Ovf = 1;
    strobe();
    check("R2 EA=0 blocks", intReq, 0);
    wrEn(8'h81);
    check("R2 EA=1 request", intReq, 1);
    check("R4 vec ext0", intVec, 0);
    tmr2Ovf = 0; strobe();
  endtask

  task automatic tMask();
    wrEn(8'hBE);
    check("R3 ext0 masked", intReq, 0);
    wrEn(8'h81);
    check("R3 unmasked req", intReq, 1);
    ackChk("R8 clr ext0", 6'b000001);
    ext0Req = 0;
    #1 check("R8 pending dropped", intReq, 0);
  endtask

  task automatic tOrder();
    wrEn(8'hBF);
    ext1Req = 1; serTx = 1; tmr2Ovf = 1;
    strobe();
    check("R4 vec ext1 first", intVec, 2);
    ackChk("R8 clr ext1", 6'b000100);
    ext1Req = 0;
    #1 check("R4 vec serial next", intVec, 4);
    ackChk("R9 no clr serial", 6'b000000);
    check("R9 serial persists", {intReq, intVec}, {1'b1, 3'd4});
    serTx = 0; strobe();
    check("R4 vec tmr2", intVec, 5);
    ackChk("R9 no clr tmr2", 6'b000000);
    check("R9 tmr2 persists", {intReq, intVec}, {1'b1, 3'd5});
    tmr2Ovf = 0; tmr2Ext = 1; strobe();
    check("R6 tmr2 via ext flag", {intReq, intVec}, {1'b1, 3'd5});
    tmr2Ext = 0; serRx = 1; strobe();
    check("R5 serial via rx", {intReq, intVec}, {1'b1, 3'd4});
    serRx = 0; strobe();
    check("R5 idle", intReq, 0);
  endtask

  task automatic tLatency();
    wrEn(8'h8A);
    tmr0Ovf = 1; tmr1Ovf = 1;
    strobe();
    check("R7 t0 not yet", intReq, 0);
    strobe();
    check("R7 t0 after 2", {intReq, intVec}, {1'b1, 3'd1});
    ackChk("R8 clr t0", 6'b000010);
    tmr0Ovf = 0;
    #1 check("R4 vec t1 next", {intReq, intVec}, {1'b1, 3'd3});
    ackChk("R8 clr t1", 6'b001000);
    tmr1Ovf = 0;
    #1 check("R8 all cleared", intReq, 0);
    strobe();
    check("R7 no stale t0", intReq, 0);
    wrEn(8'hA0);
    tmr2Ovf = 1; strobe();
    check("R7 t2 one strobe", {intReq, intVec}, {1'b1, 3'd5});
    tmr2Ovf = 0; strobe();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tEnReg();
    tGlobal();
    tMask();
    tOrder();
    tLatency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChk++; nErr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule